// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner per cycle from up to N requesters and gives precedence to the one that has gone longest without service. For every pair of requesters it keeps a single precedence bit. A requester is granted when it is requesting and no requester that outranks it is requesting. The grant is combinational from the request vector and the stored precedence state.

When a grant is issued and the update enable is high, the winner drops below every other requester. The relative order of all other requesters stays as it was. With the update enable low, the same grant can be shown again without changing the order. This lets the surrounding logic only commit a grant that it actually used.

Only the bits above the diagonal of the pairwise matrix are stored. The reverse relation is their complement, so the state is N*(N-1)/2 flops. The reset input is asynchronous and active-low. Its release is synchronised inside the block before it reaches the state. At reset the order is by index: index 0 ranks highest and index N-1 ranks lowest.

Top module: `lrs_matrix_arb`

## Requirements
- R1: After reset, a lower index outranks every higher index. With all requests high, the grant is bit 0.
- R2: The grant vector is never more than one-hot.
- R3: A grant bit is set only for a requester whose request bit is high. An all-zero request gives an all-zero grant.
- R4: Whenever at least one request bit is high, exactly one grant bit is high.
- R5: The grant goes to the requester that ranks highest in the current order among those requesting.
- R6: When requester k is granted and the update enable is high, k moves to the lowest rank on the next cycle. All others keep their relative order.
- R7: While the update enable is low, the order is unchanged, so an unchanged request vector keeps getting the same grant.
- R8: A requester that keeps requesting sees at most N-1 committed grants to other requesters before its own grant.
- R9: Take three requesters whose order, from highest to lowest rank, is 2, 1, 0, and keep all three requesting with the update enable high. The grants then run 2, 1, 0, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | N | One bit per requester asking for service |
| upd_en_i | input | 1 | Commits the current grant to the precedence order |
| gnt_o | output | N | One-hot grant, or zero when nothing requests |

## Verification
The bench builds two instances. One has N=3, so the three-requester rotation of R9 can be driven exactly and compared against the stated grant order. The other has N=6, where the random request patterns with random update enables reach longer orderings. That size gives deeper waits for the N-1 bound of R8 and more precedence pairs for the row-clear and column-set update. The expected grants come from an ordered list model that moves each served requester to the tail of the list. This gives an independent view of the same priority rule.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  // Number of stored precedence bits for n requesters.
  function automatic int unsigned pair_count(input int unsigned n);
    return (n * (n - 1)) / 2;
  endfunction

  // Flat position of the bit for the pair (a, b) with a < b.
  function automatic int unsigned pair_pos(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned n);
    return (a * n) - ((a * (a + 1)) / 2) + (b - a - 1);
  endfunction
endpackage

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/lrs_prec_store.sv
module lrs_prec_store
  import lrs_pkg::*;
#(
  parameter int unsigned N  = 3,
  localparam int unsigned NP = pair_count(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [N-1:0]  gnt,
  output logic [NP-1:0] prec_q
);
  logic [NP-1:0] prec_nxt;
  logic          commit;

  assign commit = upd_en & (|gnt);

  // Pair (a,b), a<b: bit set means a outranks b.
  // Granting a clears its row entry; granting b sets its column entry.
  for (genvar a = 0; a < N; a++) begin : g_row
    for (genvar b = a + 1; b < N; b++) begin : g_col
      localparam int unsigned P = pair_pos(a, b, N);
      assign prec_nxt[P] = gnt[a] ? 1'b0 :
                           gnt[b] ? 1'b1 : prec_q[P];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prec_q <= '1;
    else if (commit) prec_q <= prec_nxt;
  end
endmodule

// File: rtl/lrs_grant_net.sv
module lrs_grant_net
  import lrs_pkg::*;
#(
  parameter int unsigned N  = 3,
  localparam int unsigned NP = pair_count(N)
) (
  input  logic [N-1:0]  req,
  input  logic [NP-1:0] prec,
  output logic [N-1:0]  gnt
);
  // blk[i][j]: requester j is requesting and outranks i.
  logic [N-1:0] blk [N];

  for (genvar i = 0; i < N; i++) begin : g_tgt
    for (genvar j = 0; j < N; j++) begin : g_src
      if (j == i) begin : g_self
        assign blk[i][j] = 1'b0;
      end else if (j < i) begin : g_lo
        assign blk[i][j] = req[j] & prec[pair_pos(j, i, N)];
      end else begin : g_hi
        assign blk[i][j] = req[j] & ~prec[pair_pos(i, j, N)];
      end
    end
    assign gnt[i] = req[i] & ~(|blk[i]);
  end
endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb
  import lrs_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         upd_en_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned NP = pair_count(N);

  logic          rst_int_n;
  logic [NP-1:0] prec;
  logic [N-1:0]  gnt;

  lrs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lrs_prec_store #(.N(N)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .upd_en (upd_en_i),
    .gnt    (gnt),
    .prec_q (prec)
  );

  lrs_grant_net #(.N(N)) u_net (
    .req  (req_i),
    .prec (prec),
    .gnt  (gnt)
  );

  assign gnt_o = gnt;
endmodule

// File: rtl/lrs_matrix_arb_chk.sv
module lrs_matrix_arb_chk #(
  parameter int unsigned N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_i,
  input logic         upd_en_i,
  input logic [N-1:0] gnt_o
);
  localparam int unsigned CW = $clog2(N + 1) + 1;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R3
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  // R4
  work_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (|gnt_o));

  // R6
  served_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && (|gnt_o)) |=>
      (((gnt_o & $past(gnt_o)) == '0) || (req_i == $past(gnt_o))));

  for (genvar i = 0; i < N; i++) begin : g_wait
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       wait_q <= '0;
      else if (!req_i[i] || (gnt_o[i] && upd_en_i)) wait_q <= '0;
      else if (upd_en_i && (|gnt_o))   wait_q <= wait_q + 1'b1;
    end
    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= CW'(N - 1));
  end
endmodule

bind lrs_matrix_arb lrs_matrix_arb_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .upd_en_i (upd_en_i),
  .gnt_o    (gnt_o)
);

// File: tb/test_lrs_matrix_arb.sv
`timescale 1ns/1ps
module test_lrs_matrix_arb;
  logic       clk;
  logic       rst_n;
  logic [2:0] req3, gnt3;
  logic [5:0] req6, gnt6;
  logic       upd3, upd6;
  int         n_chk, n_bad;
  bit         done;

  int ord  [2][8];
  int nsz  [2];
  int wcnt [2][8];

  lrs_matrix_arb #(.N(3)) i_lrs_matrix_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req3), .upd_en_i(upd3), .gnt_o(gnt3));

  lrs_matrix_arb #(.N(6)) i_lrs_matrix_arb_wide (
    .clk(clk), .rst_n(rst_n), .req_i(req6), .upd_en_i(upd6), .gnt_o(gnt6));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int pick(int u, logic [7:0] r);
    for (int p = 0; p < nsz[u]; p++)
      if (r[ord[u][p]]) return ord[u][p];
    return -1;
  endfunction

  function automatic void serve(int u, int k);
    int pos = 0;
    for (int p = 0; p < nsz[u]; p++) if (ord[u][p] == k) pos = p;
    for (int p = pos; p < nsz[u] - 1; p++) ord[u][p] = ord[u][p+1];
    ord[u][nsz[u]-1] = k;
  endfunction

  function automatic void model_reset();
    nsz[0] = 3; nsz[1] = 6;
    for (int u = 0; u < 2; u++)
      for (int p = 0; p < 8; p++) begin
        ord[u][p] = p; wcnt[u][p] = 0;
      end
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic unit_step(int u, logic [7:0] r, logic up, logic [7:0] act,
                           string tag);
    int k;
    logic [7:0] exp;
    k = pick(u, r);
    exp = (k >= 0) ? (8'd1 << k) : 8'd0;
    check(tag, act, exp);
    for (int i = 0; i < nsz[u]; i++) begin
      if (!r[i] || (i == k && up)) wcnt[u][i] = 0;
      else if (up && k >= 0) begin
        wcnt[u][i]++;
        n_chk++;
        if (wcnt[u][i] > nsz[u] - 1) begin
          n_bad++;
          $display("FAIL R8: requester %0d waited %0d expected <= %0d",
                   i, wcnt[u][i], nsz[u] - 1);
        end
      end
    end
    if (up && k >= 0) serve(u, k);
  endtask

  task automatic step(logic [2:0] r3, logic u3, logic [5:0] r6, logic u6,
                      string tag);
    @(negedge clk);
    req3 = r3; upd3 = u3; req6 = r6; upd6 = u6;
    #1;
    unit_step(0, {5'd0, r3}, u3, {5'd0, gnt3}, {tag, " n3"});
    unit_step(1, {2'd0, r6}, u6, {2'd0, gnt6}, {tag, " n6"});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    req3 = '0; req6 = '0; upd3 = 1'b0; upd6 = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R3: idle during reset gives no grant
    check("R3 reset idle n3", {5'd0, gnt3}, 8'd0);
    check("R3 reset idle n6", {2'd0, gnt6}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R5: index order after reset
    step(3'b111, 1'b0, 6'h3F, 1'b0, "R1 all request");
    step(3'b110, 1'b0, 6'b111000, 1'b0, "R1 partial");
    // R7: no update, order kept
    for (int t = 0; t < 4; t++) step(3'b111, 1'b0, 6'h3F, 1'b0, "R7 held");
    // R3: no request, zero grant
    step(3'b000, 1'b1, 6'h00, 1'b1, "R3 idle");

    // R9: move N=3 order to 2,1,0 then rotate all-request
    step(3'b111, 1'b1, 6'h00, 1'b0, "R9 setup a");
    step(3'b010, 1'b1, 6'h00, 1'b0, "R9 setup b");
    step(3'b001, 1'b1, 6'h00, 1'b0, "R9 setup c");
    step(3'b111, 1'b1, 6'h00, 1'b0, "R9 expect 2");
    step(3'b111, 1'b1, 6'h00, 1'b0, "R9 expect 1");
    step(3'b111, 1'b1, 6'h00, 1'b0, "R9 expect 0");
    step(3'b111, 1'b1, 6'h00, 1'b0, "R9 expect 2 again");

    // R6: wide rotation under full load
    for (int t = 0; t < 8; t++) step(3'b000, 1'b0, 6'h3F, 1'b1, "R6 rotate");
    // R6: single repeat requester served then others win
    step(3'b000, 1'b0, 6'b100100, 1'b1, "R6 pair a");
    step(3'b000, 1'b0, 6'b100100, 1'b1, "R6 pair b");
    step(3'b000, 1'b0, 6'b100100, 1'b1, "R6 pair c");

    // R2 R4 R5 R8: random mix
    begin
      int unsigned seed = 32'h1F2E3D4C;
      void'($urandom(seed));
      for (int t = 0; t < 4000; t++) begin
        logic [2:0] r3;
        logic [5:0] r6;
        r3 = 3'($urandom);
        r6 = 6'($urandom) | 6'($urandom);
        step(r3, ($urandom % 4) != 0, r6, ($urandom % 4) != 0, "R5 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule